// File: doc/BRIEF.md
# Coprocessor Instruction Dispatch Sequencer

The sequencer is placed between an instruction decode stage and an external coprocessor port. The decode stage offers one instruction at a time. The sequencer classifies it into one of four kinds:

- a coprocessor data operation;
- a register transfer to the coprocessor;
- a register transfer from the coprocessor;
- a coprocessor memory load/store.

Any other instruction is ignored. For a coprocessor instruction, the sequencer broadcasts the full instruction word to the coprocessor port. It then stalls for as long as the coprocessor holds its busy line, and finishes once the coprocessor accepts. If no coprocessor accepts within a configurable number of cycles, the sequencer raises an undefined-instruction trap.

For a load/store, the sequencer computes the first word address from the base register value and a scaled 8-bit offset. It then steps the address by one word per cycle until the coprocessor marks the last word. When writeback is requested, it writes the indexed base back exactly once. For a transfer from the coprocessor, the returned word goes to a register-file write port. If the destination is register 15, only the top four bits of the word are used, and they update the condition flags.

Top module: `cop_dispatch`

## Requirements
- R1: An instruction whose bits 27:24 are 1110 is a data operation when bit 4 = 0. It is a register transfer when bit 4 = 1, with bit 20 = 1 meaning from-coprocessor and 0 meaning to-coprocessor. Bits 27:25 = 110 mark a load/store. Any other instruction is ignored: `issue_ready` stays 1, `cp_valid` stays 0 and no output pulse occurs.
- R2: From the cycle after a coprocessor instruction is issued until it is accepted, `cp_valid` is 1. During that time `cp_instr` holds the instruction unchanged, and `cp_num` equals bits 11:8 of the instruction.
- R3: While `cp_busy` is 1, the sequencer keeps broadcasting. It neither completes nor traps, however many cycles busy lasts.
- R4: If `cp_accept` and `cp_busy` both stay 0 for TIMEOUT_CYC consecutive broadcast cycles, the sequencer gives one `undef_trap` pulse, gives no `done` pulse and returns to idle.
- R5: A load/store with bit 24 (pre-index) = 0 and bit 21 (writeback) = 0 is reserved. It produces an `undef_trap` pulse in the cycle after issue and is never broadcast.
- R6: After a load/store is accepted, the sequencer asserts `mem_req` for one cycle per word.
  - The offset is four times bits 7:0. It is added when bit 23 = 1 and subtracted when bit 23 = 0.
  - The first address is base ± offset when bit 24 = 1, and the unmodified base when bit 24 = 0.
  - Each later address is the previous one plus 4.
  - `mem_we` is the inverse of bit 20.
  - The word presented while `cp_last` = 1 is the final one.
- R7: When bit 21 = 1, the sequencer gives a single `wb_we` pulse in the cycle after the last word, with `wb_addr` = bits 19:16 and `wb_data` = base ± offset. When bit 21 = 0, no `wb_we` pulse occurs.
- R8: A from-coprocessor transfer with bits 15:12 ≠ 15 gives one `rf_we` pulse in the cycle after accept. It carries `rf_waddr` = bits 15:12 and `rf_wdata` = the `cp_rdata` value present at accept.
- R9: A from-coprocessor transfer with bits 15:12 = 15 gives one `flag_we` pulse with `flags` = `cp_rdata`[31:28], and no `rf_we` pulse.
- R10: During broadcast of a to-coprocessor transfer, `cp_wdata` equals the `src_val` sampled at issue.
- R11: Each accepted instruction ends with exactly one `done` pulse: in the cycle after accept for data operations and register transfers, and in the cycle after the last word for load/stores.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| issue_valid | input | 1 | Decode stage offers an instruction |
| issue_instr | input | 32 | Offered instruction word |
| base_val | input | 32 | Value of the base register named in bits 19:16 |
| src_val | input | 32 | Value of the register named in bits 15:12 |
| issue_ready | output | 1 | Sequencer idle and able to take an instruction |
| cp_valid | output | 1 | Instruction broadcast strobe |
| cp_instr | output | 32 | Broadcast instruction word |
| cp_num | output | 4 | Target coprocessor number |
| cp_wdata | output | 32 | Word sent to the coprocessor on a to-coprocessor transfer |
| cp_accept | input | 1 | Coprocessor takes the instruction |
| cp_busy | input | 1 | Coprocessor present but not ready yet |
| cp_last | input | 1 | Current load/store word is the final one |
| cp_rdata | input | 32 | Word returned by the coprocessor |
| mem_req | output | 1 | Memory word access this cycle |
| mem_addr | output | 32 | Word address of the access |
| mem_we | output | 1 | Access is a store |
| rf_we | output | 1 | Register-file write pulse |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| flag_we | output | 1 | Condition flag update pulse |
| flags | output | 4 | New N, Z, C, V flags |
| wb_we | output | 1 | Base writeback pulse |
| wb_addr | output | 4 | Base register index |
| wb_data | output | 32 | Written-back base value |
| done | output | 1 | Accepted instruction completed |
| undef_trap | output | 1 | Undefined-instruction trap pulse |

## Verification
The bench holds busy longer than the timeout window. A design that let the timeout run during busy would trap a coprocessor that is present. It also issues the reserved post-index-without-writeback form and an instruction no coprocessor answers; a design that got these wrong would broadcast the reserved form, or hang instead of trapping. Load/stores with pre- and post-indexing, both offset signs and word counts from one to five catch designs that use the stepped address for writeback, apply the offset twice, or miss the final word. A from-coprocessor transfer to register 15 catches a design that writes the whole word to the register file instead of updating only the four flags.

// File: rtl/cop_disp_pkg.sv
package cop_disp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DISPATCH,
        ST_XFER
    } seq_state_e;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_DATAOP,
        CLS_TO_CP,
        CLS_FROM_CP,
        CLS_MEM,
        CLS_RESERVED
    } cop_class_e;

    localparam logic [3:0] FLAG_REG = 4'd15;

endpackage

// File: rtl/cop_classify.sv
module cop_classify
    import cop_disp_pkg::*;
(
    input  logic [3:0]  op_hi,
    input  logic        w_bit,
    input  logic        l_bit,
    input  logic        b4,
    output cop_class_e  cls
);

    always_comb begin
        cls = CLS_NONE;
        if (op_hi == 4'b1110) begin
            if (!b4)        cls = CLS_DATAOP;
            else if (l_bit) cls = CLS_FROM_CP;
            else            cls = CLS_TO_CP;
        end else if (op_hi[3:1] == 3'b110) begin
            // bit 24 is op_hi[0]: post-index without writeback is reserved
            if (!op_hi[0] && !w_bit) cls = CLS_RESERVED;
            else                     cls = CLS_MEM;
        end
    end

endmodule

// File: rtl/cop_addr_calc.sv
module cop_addr_calc #(
    parameter int unsigned AW     = 32,
    parameter int unsigned IMM_W  = 8
) (
    input  logic [AW-1:0]    base,
    input  logic [IMM_W-1:0] imm,
    input  logic             pre,
    input  logic             up,
    output logic [AW-1:0]    first_addr,
    output logic [AW-1:0]    indexed
);

    localparam int unsigned WORD_SHIFT = 2;

    logic [AW-1:0] offset;

    always_comb begin
        offset     = AW'(imm) << WORD_SHIFT;
        indexed    = up ? (base + offset) : (base - offset);
        first_addr = pre ? indexed : base;
    end

endmodule

// File: rtl/cop_dispatch.sv
module cop_dispatch
    import cop_disp_pkg::*;
#(
    parameter int unsigned DW          = 32,
    parameter int unsigned TIMEOUT_CYC = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_valid,
    input  logic [31:0]   issue_instr,
    input  logic [DW-1:0] base_val,
    input  logic [DW-1:0] src_val,
    output logic          issue_ready,
    output logic          cp_valid,
    output logic [31:0]   cp_instr,
    output logic [3:0]    cp_num,
    output logic [DW-1:0] cp_wdata,
    input  logic          cp_accept,
    input  logic          cp_busy,
    input  logic          cp_last,
    input  logic [DW-1:0] cp_rdata,
    output logic          mem_req,
    output logic [DW-1:0] mem_addr,
    output logic          mem_we,
    output logic          rf_we,
    output logic [3:0]    rf_waddr,
    output logic [DW-1:0] rf_wdata,
    output logic          flag_we,
    output logic [3:0]    flags,
    output logic          wb_we,
    output logic [3:0]    wb_addr,
    output logic [DW-1:0] wb_data,
    output logic          done,
    output logic          undef_trap
);

    localparam int unsigned TMO_W      = $clog2(TIMEOUT_CYC + 1);
    localparam int unsigned STEP_BYTES = 4;

    typedef struct packed {
        seq_state_e  st;
        cop_class_e  cls;
        logic [31:0] instr;
        logic [DW-1:0] src;
        logic [DW-1:0] addr;
        logic [DW-1:0] wb_val;
        logic        wb_en;
        logic [TMO_W-1:0] tmo;
        logic        done;
        logic        trap;
        logic        rf_we;
        logic [3:0]  rf_addr;
        logic [DW-1:0] rf_data;
        logic        flag_we;
        logic [3:0]  flags;
        logic        wb_we;
    } seq_reg_t;

    seq_reg_t r_d, r_q;

    cop_class_e     dec_cls;
    logic [DW-1:0]  calc_first;
    logic [DW-1:0]  calc_indexed;

    cop_classify u_classify (
        .op_hi (issue_instr[27:24]),
        .w_bit (issue_instr[21]),
        .l_bit (issue_instr[20]),
        .b4    (issue_instr[4]),
        .cls   (dec_cls)
    );

    cop_addr_calc #(.AW(DW), .IMM_W(8)) u_addr (
        .base       (base_val),
        .imm        (issue_instr[7:0]),
        .pre        (issue_instr[24]),
        .up         (issue_instr[23]),
        .first_addr (calc_first),
        .indexed    (calc_indexed)
    );

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.trap    = 1'b0;
        r_d.rf_we   = 1'b0;
        r_d.flag_we = 1'b0;
        r_d.wb_we   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (issue_valid) begin
                    if (dec_cls == CLS_RESERVED) begin
                        r_d.trap = 1'b1;
                    end else if (dec_cls != CLS_NONE) begin
                        r_d.st     = ST_DISPATCH;
                        r_d.cls    = dec_cls;
                        r_d.instr  = issue_instr;
                        r_d.src    = src_val;
                        r_d.addr   = calc_first;
                        r_d.wb_val = calc_indexed;
                        r_d.wb_en  = issue_instr[21];
                        r_d.tmo    = '0;
                    end
                end
            end
            ST_DISPATCH: begin
                if (cp_busy) begin
                    r_d.tmo = '0;
                end else if (cp_accept) begin
                    unique case (r_q.cls)
                        CLS_MEM: r_d.st = ST_XFER;
                        CLS_FROM_CP: begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                            if (r_q.instr[15:12] == FLAG_REG) begin
                                r_d.flag_we = 1'b1;
                                r_d.flags   = cp_rdata[DW-1 -: 4];
                            end else begin
                                r_d.rf_we   = 1'b1;
                                r_d.rf_addr = r_q.instr[15:12];
                                r_d.rf_data = cp_rdata;
                            end
                        end
                        default: begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                        end
                    endcase
                end else if (r_q.tmo == TMO_W'(TIMEOUT_CYC - 1)) begin
                    r_d.st   = ST_IDLE;
                    r_d.trap = 1'b1;
                end else begin
                    r_d.tmo = r_q.tmo + 1'b1;
                end
            end
            ST_XFER: begin
                r_d.addr = r_q.addr + DW'(STEP_BYTES);
                if (cp_last) begin
                    r_d.st    = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.wb_we = r_q.wb_en;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign issue_ready = (r_q.st == ST_IDLE);
    assign cp_valid    = (r_q.st == ST_DISPATCH);
    assign cp_instr    = r_q.instr;
    assign cp_num      = r_q.instr[11:8];
    assign cp_wdata    = (cp_valid && r_q.cls == CLS_TO_CP) ? r_q.src : '0;
    assign mem_req     = (r_q.st == ST_XFER);
    assign mem_addr    = r_q.addr;
    assign mem_we      = mem_req & ~r_q.instr[20];
    assign rf_we       = r_q.rf_we;
    assign rf_waddr    = r_q.rf_addr;
    assign rf_wdata    = r_q.rf_data;
    assign flag_we     = r_q.flag_we;
    assign flags       = r_q.flags;
    assign wb_we       = r_q.wb_we;
    assign wb_addr     = r_q.instr[19:16];
    assign wb_data     = r_q.wb_val;
    assign done        = r_q.done;
    assign undef_trap  = r_q.trap;

    // R2: broadcast word must not change while the strobe is held
    p_instr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_valid && $past(cp_valid)) |-> $stable(cp_instr));

    // R3: busy keeps the broadcast going
    p_busy_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_valid && cp_busy) |=> cp_valid);

    // R4: trap and completion never coincide
    p_trap_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(undef_trap && done));

    // R6: consecutive words are one word apart
    p_mem_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + DW'(STEP_BYTES)));

    // R7: writeback only directly after a memory word
    p_wb_after_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we |-> $past(mem_req));

    // R9: flag update and register write are exclusive
    p_flag_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_we && rf_we));

    // R11: completion pulse lasts one cycle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/test_cop_dispatch.sv
module test_cop_dispatch;

    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [31:0] issue_instr = '0;
    logic [31:0] base_val = '0;
    logic [31:0] src_val = '0;
    logic        issue_ready, cp_valid;
    logic [31:0] cp_instr, cp_wdata;
    logic [3:0]  cp_num;
    logic        cp_accept = 1'b0, cp_busy = 1'b0, cp_last = 1'b0;
    logic [31:0] cp_rdata = '0;
    logic        mem_req, mem_we, rf_we, flag_we, wb_we, done, undef_trap;
    logic [31:0] mem_addr, rf_wdata, wb_data;
    logic [3:0]  rf_waddr, flags, wb_addr;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [39:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    cop_dispatch #(.DW(32), .TIMEOUT_CYC(TMO)) i_cop_dispatch (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_instr(issue_instr),
        .base_val(base_val), .src_val(src_val), .issue_ready(issue_ready),
        .cp_valid(cp_valid), .cp_instr(cp_instr), .cp_num(cp_num), .cp_wdata(cp_wdata),
        .cp_accept(cp_accept), .cp_busy(cp_busy), .cp_last(cp_last), .cp_rdata(cp_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_we(mem_we),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .flag_we(flag_we), .flags(flags), .wb_we(wb_we), .wb_addr(wb_addr),
        .wb_data(wb_data), .done(done), .undef_trap(undef_trap)
    );

    task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // event kinds: 1 mem {we,addr}, 2 rf {reg,data}, 3 flags, 4 wb {reg,data}, 5 trap, 6 done
    task automatic push(input logic [3:0] kind, input logic [3:0] aux, input logic [31:0] data, input string tag);
        exp_q.push_back({kind, aux, data});
        tag_q.push_back(tag);
    endtask

    task automatic sb_check(input logic [39:0] got);
        logic [39:0] e;
        string t;
        if (exp_q.size() == 0) begin
            chk(1'b0, "unexpected event R1", got, 40'h0);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(got == e, t, got, e);
        end
    endtask

    // monitor: fixed order within a cycle mem, rf, flag, wb, trap, done
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req)    sb_check({4'd1, 3'b0, mem_we, mem_addr});
            if (rf_we)      sb_check({4'd2, rf_waddr, rf_wdata});
            if (flag_we)    sb_check({4'd3, flags, 32'd0});
            if (wb_we)      sb_check({4'd4, wb_addr, wb_data});
            if (undef_trap) sb_check({4'd5, 4'd0, 32'd0});
            if (done)       sb_check({4'd6, 4'd0, 32'd0});
        end
    end

    task automatic run_op(input logic [31:0] ins, input logic [31:0] base, input logic [31:0] src,
                          input int busy_n, input int words, input logic [31:0] rdata,
                          input bit present);
        @(negedge clk);
        issue_valid = 1'b1; issue_instr = ins; base_val = base; src_val = src;
        @(negedge clk);
        issue_valid = 1'b0;
        if (present) begin
            for (int i = 0; i < busy_n; i++) begin
                cp_busy = 1'b1;
                @(negedge clk);
                chk(cp_valid && !issue_ready && !undef_trap, "R3 stall under busy",
                    {38'd0, cp_valid, undef_trap}, 40'h2);
            end
            cp_busy = 1'b0;
            cp_accept = 1'b1;
            cp_rdata = rdata;
            chk(cp_valid && cp_num == ins[11:8] && cp_instr == ins, "R2 broadcast",
                {3'd0, cp_valid, cp_num, cp_instr}, {4'd1, ins[11:8], ins});
            if (ins[27:24] == 4'hE && ins[4] && !ins[20])
                chk(cp_wdata == src, "R10 write data", {8'd0, cp_wdata}, {8'd0, src});
            @(negedge clk);
            cp_accept = 1'b0;
            for (int i = 0; i < words; i++) begin
                cp_last = (i == words - 1);
                @(negedge clk);
            end
            cp_last = 1'b0;
        end else begin
            repeat (TMO + 3) @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic exp_mem(input logic [31:0] first, input int n, input bit we, input string tag);
        for (int i = 0; i < n; i++) push(4'd1, {3'b0, we}, first + 32'(4 * i), tag);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            chk(1'b0, "watchdog", 40'(cycles), 40'd0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(issue_ready && !cp_valid && !mem_req && !done && !undef_trap, "reset state",
            {35'd0, issue_ready, cp_valid, mem_req, done, undef_trap}, 40'h10);

        // R1: non-coprocessor instruction ignored
        @(negedge clk);
        issue_valid = 1'b1; issue_instr = 32'hE1A00000;
        @(negedge clk);
        issue_valid = 1'b0;
        chk(issue_ready && !cp_valid, "R1 ignored instruction", {38'd0, issue_ready, cp_valid}, 40'h2);
        repeat (3) @(negedge clk);

        // R1 R11: data operation, coprocessor 4
        push(4'd6, 4'd0, 32'd0, "R11 done dataop");
        run_op(32'hEE123440, 32'd0, 32'd0, 0, 0, 32'd0, 1'b1);

        // R3: busy longer than timeout window
        push(4'd6, 4'd0, 32'd0, "R3 done after long busy");
        run_op(32'hEE123440, 32'd0, 32'd0, TMO + 4, 0, 32'd0, 1'b1);

        // R10: to-coprocessor transfer
        push(4'd6, 4'd0, 32'd0, "R10 done");
        run_op(32'hEE005710, 32'd0, 32'hCAFE1234, 2, 0, 32'd0, 1'b1);

        // R8: from-coprocessor to register 3
        push(4'd2, 4'd3, 32'h12345678, "R8 register write");
        push(4'd6, 4'd0, 32'd0, "R8 done");
        run_op(32'hEE103210, 32'd0, 32'd0, 1, 0, 32'h12345678, 1'b1);

        // R9: from-coprocessor to register 15
        push(4'd3, 4'hA, 32'd0, "R9 flags");
        push(4'd6, 4'd0, 32'd0, "R9 done");
        run_op(32'hEE10F210, 32'd0, 32'd0, 0, 0, 32'hA5FFFFFF, 1'b1);

        // R6 R7: pre-index load, add, no writeback, 3 words
        exp_mem(32'h00001014, 3, 1'b0, "R6 pre-index load address");
        push(4'd6, 4'd0, 32'd0, "R11 done load");
        run_op(32'hED910105, 32'h00001000, 32'd0, 0, 3, 32'd0, 1'b1);

        // R6 R7: pre-index store, subtract, writeback, 2 words
        exp_mem(32'h00001FE0, 2, 1'b1, "R6 pre-index store address");
        push(4'd4, 4'd2, 32'h00001FE0, "R7 writeback pre-index");
        push(4'd6, 4'd0, 32'd0, "R11 done store");
        run_op(32'hED621108, 32'h00002000, 32'd0, 1, 2, 32'd0, 1'b1);

        // R6 R7: post-index load, subtract, single word
        exp_mem(32'h00003000, 1, 1'b0, "R6 post-index single word");
        push(4'd4, 4'd3, 32'h00002F6C, "R7 writeback post-index");
        push(4'd6, 4'd0, 32'd0, "R11 done post load");
        run_op(32'hEC331125, 32'h00003000, 32'd0, 0, 1, 32'd0, 1'b1);

        // R6 R7: post-index store, add, 5 words
        exp_mem(32'h00004000, 5, 1'b1, "R6 five word store");
        push(4'd4, 4'd4, 32'h00004004, "R7 writeback five words");
        push(4'd6, 4'd0, 32'd0, "R11 done five words");
        run_op(32'hECA40301, 32'h00004000, 32'd0, 3, 5, 32'd0, 1'b1);

        // R5: reserved post-index without writeback
        push(4'd5, 4'd0, 32'd0, "R5 reserved trap");
        @(negedge clk);
        issue_valid = 1'b1; issue_instr = 32'hEC910105; base_val = 32'h100;
        @(negedge clk);
        issue_valid = 1'b0;
        chk(!cp_valid, "R5 no broadcast", {39'd0, cp_valid}, 40'h0);
        repeat (4) @(negedge clk);

        // R4: nobody answers
        push(4'd5, 4'd0, 32'd0, "R4 absent coprocessor trap");
        run_op(32'hEE123940, 32'd0, 32'd0, 0, 0, 32'd0, 1'b0);
        chk(!cp_valid && issue_ready, "R4 idle after trap", {38'd0, cp_valid, issue_ready}, 40'h1);

        chk(exp_q.size() == 0, "scoreboard drained R11", 40'(exp_q.size()), 40'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule